// File: doc/BRIEF.md
# Indexed Peripheral Reset Controller

This block holds a bank of 32-bit peripheral reset registers and one software system-reset register. Each bit of a bank register drives one peripheral reset line, and a set bit holds that peripheral in reset. Software can reach the registers through a plain register bus. Drivers can also name a single line on a command port, using a packed identifier. The upper byte of the identifier is the byte offset of the bank register, and the lower byte is the bit index.

Three operations act on a named line: set its bit, clear its bit, and report its state. A set or clear is a read-modify-write that finishes in the cycle it is accepted. Every other bit of the register keeps its value. If a bus write hits the same register in that same cycle, the command is applied on top of the written value. A fourth operation requests a restart. It loads the system-reset register with a value chosen by a build-time number and pulses a request output. Identifiers that do not decode are rejected with a one-cycle error flag, and nothing changes.

The bank has either three registers, at offsets 0x20, 0x24 and 0x34, or four, which adds offset 0x74. Bank register k, counted in that offset order, drives `periph_rst[k*32 +: 32]`.

Top module: `indexed_rst_ctrl`

## Requirements
- R1: After a synchronous reset, every bank register, the system-reset register, `periph_rst`, `sys_rst_req`, `cmd_done`, `cmd_err` and `cmd_state` are zero.
- R2: Command op 0 (set) with a valid identifier sets bit `cmd_id[4:0]` of the register at offset `cmd_id[15:8]`. The change is visible on `periph_rst` and `bus_rdata` in the cycle after acceptance, and all other bits are unchanged.
- R3: Command op 1 (clear) with a valid identifier clears that bit only, with the same timing.
- R4: Command op 2 (status) with a valid identifier drives the selected bit on `cmd_state` in the cycle after acceptance. It changes no register.
- R5: An identifier whose offset byte is not a bank offset pulses `cmd_err` for one cycle and leaves every register unchanged.
- R6: An identifier whose bit-index byte `cmd_id[7:0]` is 32 or more is rejected the same way, even when its low five bits name a real bit.
- R7: Each command presented with `cmd_valid` produces exactly one of `cmd_done` or `cmd_err`, high for one cycle, in the cycle after it is presented.
- R8: A bus write to a bank offset replaces that register. A write to any other offset except 0x14 changes nothing. `bus_rdata` returns the addressed register without delay, and returns zero for unmapped offsets.
- R9: When a bus write and a set or clear hit the same register in one cycle, the result is the written value with the command's bit then set or cleared.
- R10: Command op 3 (restart), with the build-time restart number N in 1..4, loads offset 0x14 with (1<<2)<<N. It raises `sys_rst_req` for one cycle and signals `cmd_done`.
- R11: With N outside 1..4, op 3 is rejected with `cmd_err` and `sys_rst_req` stays low.
- R12: In the three-register build, offset 0x74 is rejected as invalid. Offsets 0x20, 0x24 and 0x34 behave as in the four-register build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset for read and write |
| bus_wdata | input | REG_W | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | REG_W | Read data of the addressed register (combinational) |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 set, 1 clear, 2 status, 3 restart |
| cmd_id | input | ID_W | Line identifier: offset in upper byte, bit index in lower byte |
| cmd_done | output | 1 | Command accepted (one-cycle pulse) |
| cmd_err | output | 1 | Command rejected (one-cycle pulse) |
| cmd_state | output | 1 | Line state captured by the last status command |
| periph_rst | output | NUM_REGS*REG_W | Peripheral reset lines, one bit per line |
| sys_rst_req | output | 1 | System restart request pulse |

## Verification
The bench sweeps every bit of every bank register through set, clear and status. After each step it compares the whole reset vector with an arithmetic model. A read-modify-write that disturbed a neighbouring bit, or that decoded the wrong register, would show up right there. Every one of the 256 offset bytes and every bit-index byte from 32 to 255 is tried. An index check that looked only at the low five bits would then wrongly set a bit. An offset decoder that was too loose would set a bit in some register instead of raising an error. The bench also issues a bus write and a command to one register in the same cycle, to catch an update that is lost. A second instance, with three registers and restart disabled, confirms that offset 0x74 and the restart operation are refused.

// File: rtl/rstc_pkg.sv
// Package: shared operation codes and the bank offset map for the indexed
// reset controller. Assumes byte offsets fit in eight bits.
package rstc_pkg;

    typedef enum logic [1:0] {
        OP_SET     = 2'd0,
        OP_CLR     = 2'd1,
        OP_STAT    = 2'd2,
        OP_RESTART = 2'd3
    } rstc_op_e;

    localparam logic [7:0] SYSRST_OFS = 8'h14;
    localparam int         FIELD_W    = 8;

    // Byte offset of bank register k, in bank order.
    function automatic logic [7:0] bank_offset(input int k);
        case (k)
            0:       return 8'h20;
            1:       return 8'h24;
            2:       return 8'h34;
            default: return 8'h74;
        endcase
    endfunction

endpackage

// File: rtl/rstc_id_check.sv
// Identifier decoder: splits a line identifier into register select and bit
// index and flags it valid only for a known offset and an index below REG_W.
// Assumes the identifier is two FIELD_W-bit fields, offset above index.
module rstc_id_check
    import rstc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 32,
    parameter int ID_W     = 16,
    parameter int IDX_W    = $clog2(REG_W)
) (
    input  logic [ID_W-1:0]     id,
    output logic                ok,
    output logic [NUM_REGS-1:0] sel,
    output logic [IDX_W-1:0]    bit_idx
);
    logic [ID_W-FIELD_W-1:0] ofs;
    logic [FIELD_W-1:0]      idx;
    logic                    in_range;

    assign ofs = id[ID_W-1:FIELD_W];
    assign idx = id[FIELD_W-1:0];

    // One match line per bank register.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_match
        assign sel[k] = (ofs == bank_offset(k));
    end

    // Index must have no bits above the in-register range.
    always_comb in_range = (idx[FIELD_W-1:IDX_W] == '0);

    assign ok      = (|sel) && in_range;
    assign bit_idx = idx[IDX_W-1:0];

endmodule

// File: rtl/rstc_reg_slice.sv
// One bank register: a bus write replaces it, then a command sets or clears
// one bit on top of that, all in the same cycle (atomic read-modify-write).
// Assumes at most one command hit per cycle.
module rstc_reg_slice #(
    parameter int              REG_W  = 32,
    parameter int              ADDR_W = 8,
    parameter int              IDX_W  = $clog2(REG_W),
    parameter logic [ADDR_W-1:0] OFFSET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              cmd_hit,
    input  logic              cmd_set,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [REG_W-1:0]  q
);
    logic [REG_W-1:0] base, mask, nxt;

    // Merge the bus write first, then the single-bit command.
    always_comb begin
        base = (bus_we && bus_addr == OFFSET) ? bus_wdata : q;
        mask = REG_W'(1) << bit_idx;
        if (cmd_hit) nxt = cmd_set ? (base | mask) : (base & ~mask);
        else         nxt = base;
    end

    // Register state, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

endmodule

// File: rtl/rstc_restart.sv
// System-reset register and request pulse. A restart trigger loads
// (1<<2)<<SEL when SEL is 1..4; bus writes load it directly. Any nonzero load
// raises the request for one cycle. Assumes trig is only raised when en is set.
module rstc_restart #(
    parameter int                REG_W  = 32,
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = '0,
    parameter int                SEL    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              trig,
    output logic [REG_W-1:0]  q,
    output logic              req,
    output logic              en
);
    localparam bit               EN  = (SEL >= 1) && (SEL <= 4);
    localparam logic [REG_W-1:0] VAL = EN ? (REG_W'(4) << SEL) : '0;

    logic wr;
    assign wr = bus_we && (bus_addr == OFFSET);
    assign en = EN;

    // Register and one-cycle request; the trigger wins over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            req <= 1'b0;
        end else begin
            if (trig && EN) q <= VAL;
            else if (wr)    q <= bus_wdata;
            req <= (trig && EN) || (wr && |bus_wdata);
        end
    end

endmodule

// File: rtl/indexed_rst_ctrl.sv
// Top: indexed peripheral reset controller. Decodes line identifiers, applies
// set/clear in one cycle, reports status and restart, and serves a register
// bus. Assumes one command per cycle; responses appear the following cycle.
module indexed_rst_ctrl
    import rstc_pkg::*;
#(
    parameter bit  HAS_BANK4   = 1'b1,
    parameter int  RESTART_SEL = 2,
    parameter int  REG_W       = 32,
    parameter int  ADDR_W      = 8,
    parameter int  ID_W        = 16,
    localparam int NUM_REGS    = 3 + int'(HAS_BANK4),
    localparam int IDX_W       = $clog2(REG_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [REG_W-1:0]          bus_wdata,
    input  logic                      bus_we,
    output logic [REG_W-1:0]          bus_rdata,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic [ID_W-1:0]           cmd_id,
    output logic                      cmd_done,
    output logic                      cmd_err,
    output logic                      cmd_state,
    output logic [NUM_REGS*REG_W-1:0] periph_rst,
    output logic                      sys_rst_req
);
    rstc_op_e            op;
    logic                id_ok, rs_en, is_rw, cmd_bad, stat_bit;
    logic [NUM_REGS-1:0] sel;
    logic [IDX_W-1:0]    bit_idx;
    logic [REG_W-1:0]    bank_q [NUM_REGS];
    logic [REG_W-1:0]    sys_q;

    assign op = rstc_op_e'(cmd_op);

    rstc_id_check #(
        .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ID_W(ID_W), .IDX_W(IDX_W)
    ) u_idchk (
        .id(cmd_id), .ok(id_ok), .sel(sel), .bit_idx(bit_idx)
    );

    assign is_rw = cmd_valid && id_ok && (op == OP_SET || op == OP_CLR);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
        rstc_reg_slice #(
            .REG_W(REG_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
            .OFFSET(ADDR_W'(bank_offset(k)))
        ) u_slice (
            .clk(clk), .rst_n(rst_n),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
            .cmd_hit(is_rw && sel[k]), .cmd_set(op == OP_SET),
            .bit_idx(bit_idx), .q(bank_q[k])
        );
        assign periph_rst[k*REG_W +: REG_W] = bank_q[k];
    end

    rstc_restart #(
        .REG_W(REG_W), .ADDR_W(ADDR_W),
        .OFFSET(ADDR_W'(SYSRST_OFS)), .SEL(RESTART_SEL)
    ) u_restart (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .trig(cmd_valid && op == OP_RESTART && rs_en),
        .q(sys_q), .req(sys_rst_req), .en(rs_en)
    );

    // Pick the addressed bit of the selected bank register for status.
    always_comb begin
        stat_bit = 1'b0;
        for (int k = 0; k < NUM_REGS; k++)
            if (sel[k]) stat_bit = bank_q[k][bit_idx];
    end

    // Reject a bad identifier, or a restart when restart is disabled.
    always_comb begin
        if (op == OP_RESTART) cmd_bad = cmd_valid && !rs_en;
        else                  cmd_bad = cmd_valid && !id_ok;
    end

    // Response flags and captured status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_done  <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_state <= 1'b0;
        end else begin
            cmd_done <= cmd_valid && !cmd_bad;
            cmd_err  <= cmd_bad;
            if (cmd_valid && op == OP_STAT && id_ok) cmd_state <= stat_bit;
        end
    end

    // Combinational read mux over all mapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(SYSRST_OFS)) bus_rdata = sys_q;
        for (int k = 0; k < NUM_REGS; k++)
            if (bus_addr == ADDR_W'(bank_offset(k))) bus_rdata = bank_q[k];
    end

endmodule

// File: rtl/rstc_checker.sv
// Checker: temporal properties of the reset controller's ports, bound to
// every instance of the top module.
module rstc_checker
    import rstc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic [1:0]                cmd_op,
    input logic                      bus_we,
    input logic                      cmd_done,
    input logic                      cmd_err,
    input logic [NUM_REGS*REG_W-1:0] periph_rst,
    input logic                      sys_rst_req
);
    // R1: lines are clear on the first cycle out of reset.
    p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> periph_rst == '0);

    // R7: done and error never together.
    p_one_response_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && cmd_err));

    // R7: a done pulse follows a presented command.
    p_done_follows_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(cmd_valid));

    // R5: an error follows a presented command.
    p_err_follows_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid));

    // R5: a rejected command without a bus write leaves all lines alone.
    p_err_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !$past(bus_we)) |-> $stable(periph_rst));

    // R4: status alone does not move any line.
    p_status_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && $past(cmd_op) == OP_STAT && !$past(bus_we))
            |-> $stable(periph_rst));

    // R10: a restart request comes only from a command or a bus write.
    p_req_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> ($past(cmd_valid) || $past(bus_we)));

endmodule

bind indexed_rst_ctrl rstc_checker #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W)
) u_rstc_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .bus_we(bus_we), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .periph_rst(periph_rst), .sys_rst_req(sys_rst_req)
);

// File: tb/tb_indexed_rst_ctrl.sv
`timescale 1ns/1ps
module tb_indexed_rst_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] cmd_id = '0;

    logic [31:0]  rdata, rdata_s;
    logic         done, err, state, req;
    logic         done_s, err_s, state_s, req_s;
    logic [127:0] prst;
    logic [95:0]  prst_s;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [4];

    always #2.5 clk = ~clk;

    indexed_rst_ctrl #(.HAS_BANK4(1'b1), .RESTART_SEL(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_done(done), .cmd_err(err),
        .cmd_state(state), .periph_rst(prst), .sys_rst_req(req)
    );

    indexed_rst_ctrl #(.HAS_BANK4(1'b0), .RESTART_SEL(0)) dut_small (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rdata_s), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_done(done_s), .cmd_err(err_s),
        .cmd_state(state_s), .periph_rst(prst_s), .sys_rst_req(req_s)
    );

    function automatic logic [7:0] ofs_of(input int k);
        case (k)
            0: return 8'h20;  1: return 8'h24;
            2: return 8'h34;  default: return 8'h74;
        endcase
    endfunction

    function automatic int reg_of(input logic [7:0] o, input int nregs);
        for (int k = 0; k < nregs; k++) if (ofs_of(k) == o) return k;
        return -1;
    endfunction

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic chk_vec(input string rq);
        chk(rq, prst, {mdl[3], mdl[2], mdl[1], mdl[0]});
        chk({rq, " R12 small"}, {32'd0, prst_s}, {32'd0, mdl[2], mdl[1], mdl[0]});
    endtask

    // Present one command for one cycle; outputs are sampled at the next negedge.
    task automatic cmd(input logic [1:0] op, input logic [15:0] id);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Command with model update and response checks on both instances.
    task automatic run(input logic [1:0] op, input logic [7:0] o, input logic [7:0] idx, input string rq);
        int k4 = reg_of(o, 4);
        int k3 = reg_of(o, 3);
        bit ok4 = (k4 >= 0) && (idx < 8'd32);
        bit ok3 = (k3 >= 0) && (idx < 8'd32);
        logic exp_st = ok4 ? mdl[k4][idx[4:0]] : 1'b0;
        cmd(op, {o, idx});
        if (ok4 && op == 2'd0) mdl[k4][idx[4:0]] = 1'b1;
        if (ok4 && op == 2'd1) mdl[k4][idx[4:0]] = 1'b0;
        chk({rq, " R7 done"}, 128'(done), 128'(ok4));
        chk({rq, " R7 err"},  128'(err),  128'(!ok4));
        chk({rq, " R12 small err"}, 128'(err_s), 128'(!ok3));
        if (op == 2'd2 && ok4) chk({rq, " R4 state"}, 128'(state), 128'(exp_st));
        chk_vec(rq);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        for (int k = 0; k < 4; k++) if (ofs_of(k) == a) mdl[k] = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string rq);
        bus_addr = a;
        #0.5;
        chk(rq, 128'(rdata), 128'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) mdl[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_vec("R1 reset lines");
        chk("R1 flags", {124'd0, done, err, state, req}, 128'd0);
        chk("R1 small flags", {124'd0, done_s, err_s, state_s, req_s}, 128'd0);
        for (int k = 0; k < 4; k++) rd(ofs_of(k), 32'd0, "R1 readback");
        rd(8'h14, 32'd0, "R1 sysreg");

        // R2: set every bit of every register
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 32; b++) run(2'd0, ofs_of(k), 8'(b), "R2 set");
        // R3: clear even bits
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 32; b += 2) run(2'd1, ofs_of(k), 8'(b), "R3 clear");
        // R4: status of every line
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 32; b++) run(2'd2, ofs_of(k), 8'(b), "R4 status");
        // R5: every offset byte that is not a bank offset (0x74 also for small)
        for (int o = 0; o < 256; o++)
            if (reg_of(8'(o), 4) < 0 || o == 8'h74) run(2'd1, 8'(o), 8'd2, "R5 offset");
        // R6: bit-index byte from 32 up
        for (int i = 32; i < 256; i++) run(2'd0, 8'h24, 8'(i), "R6 index");

        // R8: bus writes and reads
        bus_wr(8'h20, 32'hDEAD_BEEF);
        bus_wr(8'h74, 32'h0123_4567);
        chk_vec("R8 bus write");
        rd(8'h20, 32'hDEAD_BEEF, "R8 read 20");
        rd(8'h74, 32'h0123_4567, "R8 read 74");
        bus_wr(8'h28, 32'hFFFF_FFFF);
        chk_vec("R8 unmapped write");
        rd(8'h28, 32'd0, "R8 unmapped read");

        // R9: same-cycle bus write and command on one register
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h34; bus_wdata = 32'hA5A5_0000;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = 16'h3400;
        @(negedge clk);
        bus_we = 1'b0; cmd_valid = 1'b0;
        mdl[2] = 32'hA5A5_0001;
        chk_vec("R9 write+set");
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h24; bus_wdata = 32'hFFFF_FFFF;
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_id = 16'h241F;
        @(negedge clk);
        bus_we = 1'b0; cmd_valid = 1'b0;
        mdl[1] = 32'h7FFF_FFFF;
        chk_vec("R9 write+clear");

        // R10 / R11: restart
        cmd(2'd3, 16'h0000);
        chk("R10 done", 128'(done), 128'd1);
        chk("R10 req", 128'(req), 128'd1);
        chk("R11 small err", 128'(err_s), 128'd1);
        chk("R11 small req", 128'(req_s), 128'd0);
        rd(8'h14, 32'h0000_0010, "R10 sysreg");
        @(negedge clk);
        chk("R10 req pulse", 128'(req), 128'd0);
        chk_vec("R10 lines untouched");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule